// File: doc/BRIEF.md
# Device Reset Sequencer

This block runs the device-wide reset sequence. A sequence can start in two ways. The first is a falling edge on the asynchronous active-low reset pin, which passes through a synchroniser before its edge is detected. The second is a strobe that marks a write setting the software reset bit. When a sequence starts, the block sends one clear pulse to every internal register. It then holds a busy flag high for a programmable number of clock cycles. The same busy level also blocks writes from the serial interface. The register file and the command decoder sit outside this block and act on these outputs.

The pin acts only on its edges. When a sequence ends, a pin that is still held low does nothing until it goes high and then falls again. A software-started sequence finishes only when two things are true. The cycle count must have elapsed, and a no-operation command must have arrived after the cycle in which the reset bit was set. The pending software bit clears itself when the sequence ends. Requests that arrive while a sequence is running are dropped, not queued.

Top module: `rst_sequencer`

## Requirements
- R1: While `arst_n` is low, and at its release, `busy`, `reg_clear` and `wr_block` are all low.
- R2: A falling edge of `rst_pin_n` raises `busy` three clock edges after the pin changes, because of the two-flop synchroniser and the edge register.
- R3: A sequence started by the pin keeps `busy` high for exactly `SEQ_CYCLES` clock cycles, whatever `nop_cmd` does.
- R4: `reg_clear` is high for exactly one cycle, the first cycle in which `busy` is high, and at no other time.
- R5: `wr_block` is high in every cycle in which `busy` is high, and low in every other cycle.
- R6: A low level held on `rst_pin_n` after a sequence ends starts nothing. Only a new high-to-low transition starts a further sequence.
- R7: When the block is idle, `sw_rst_set` sampled high on a clock edge raises `busy` on that same edge.
- R8: A software sequence ends on the first edge where two conditions both hold. At least `SEQ_CYCLES` busy cycles have passed, and `nop_cmd` is high on that edge or was high on an earlier edge after the start. So `busy` lasts `SEQ_CYCLES` cycles when the no-op comes early, and N cycles when the no-op is sampled on the Nth edge after the start, for N at least `SEQ_CYCLES`.
- R9: A `nop_cmd` sampled on the same edge as the `sw_rst_set` that starts a sequence does not count toward ending that sequence.
- R10: `nop_cmd` while idle has no effect. This includes a no-op sent after a software sequence has ended, since the software bit has already cleared.
- R11: While `busy` is high, a new pin falling edge and `sw_rst_set` are both ignored and never lead to a later sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset of the sequencer itself |
| rst_pin_n | input | 1 | Asynchronous active-low device reset pin |
| sw_rst_set | input | 1 | One-cycle strobe: a write set the software reset bit |
| nop_cmd | input | 1 | One-cycle strobe: a no-operation command was decoded |
| reg_clear | output | 1 | One-cycle synchronous clear to all internal registers |
| busy | output | 1 | High for the whole reset sequence |
| wr_block | output | 1 | High while serial writes must be dropped |

## Verification
If the source of a sequence is latched wrongly, the port shows the wrong busy length, either SEQ_CYCLES or the no-op-gated length. If the no-op latch is wrong, the same thing happens. In both cases the error appears at the falling edge of `busy`, at most one no-op after the expected end. A broken edge detector shows up within a few cycles. It either produces an extra `busy` pulse while the pin is held low or misses a pulse on a fresh fall. A scoreboard of expected pulse lengths catches both. A stuck clear or write-block output differs from `busy` on the first cycle of the next sequence.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   typedef enum logic {
      SRC_PIN  = 1'b0,
      SRC_SOFT = 1'b1
   } seq_src_e;
endpackage

// File: rtl/rseq_pin_sync.sv
module rseq_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic pin_n,
   output logic fall
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("rseq_pin_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_n};
         prev_q  <= chain_q[LAST];
      end
   end

   assign fall = prev_q & ~chain_q[LAST];
endmodule

// File: rtl/rseq_timer.sv
module rseq_timer #(
   parameter int CYCLES = 12000
) (
   input  logic clk,
   input  logic arst_n,
   input  logic load,
   output logic expired
);
   localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   if (CYCLES < 2) begin : g_bad_cycles
      $error("rseq_timer: CYCLES must be at least 2");
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= LOAD_VAL;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
   import rseq_pkg::*;
#(
   parameter int SEQ_CYCLES  = 12000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic rst_pin_n,
   input  logic sw_rst_set,
   input  logic nop_cmd,
   output logic reg_clear,
   output logic busy,
   output logic wr_block
);
   seq_state_e state_q;
   seq_src_e   src_q;
   logic       nop_seen_q;
   logic       clr_q;
   logic       pin_fall;
   logic       expired;
   logic       start;
   logic       finish;

   rseq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .pin_n  (rst_pin_n),
      .fall   (pin_fall)
   );

   assign start = (state_q == SEQ_IDLE) && (pin_fall || sw_rst_set);

   rseq_timer #(.CYCLES(SEQ_CYCLES)) u_timer (
      .clk     (clk),
      .arst_n  (arst_n),
      .load    (start),
      .expired (expired)
   );

   assign finish = (state_q == SEQ_RUN) && expired &&
                   ((src_q == SRC_PIN) || nop_seen_q || nop_cmd);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state_q    <= SEQ_IDLE;
         src_q      <= SRC_PIN;
         nop_seen_q <= 1'b0;
         clr_q      <= 1'b0;
      end else begin
         clr_q <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q    <= SEQ_RUN;
                  src_q      <= pin_fall ? SRC_PIN : SRC_SOFT;
                  nop_seen_q <= 1'b0;
                  clr_q      <= 1'b1;
               end
            end
            SEQ_RUN: begin
               if (finish) begin
                  state_q    <= SEQ_IDLE;
                  nop_seen_q <= 1'b0;
               end else if ((src_q == SRC_SOFT) && nop_cmd) begin
                  nop_seen_q <= 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy      = (state_q == SEQ_RUN);
   assign reg_clear = clr_q;
   assign wr_block  = (state_q == SEQ_RUN);
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk (
   input logic clk,
   input logic arst_n,
   input logic sw_rst_set,
   input logic nop_cmd,
   input logic reg_clear,
   input logic busy,
   input logic wr_block,
   input logic pin_fall,
   input logic expired,
   input logic src_soft,
   input logic nop_seen
);
   // R4
   clr_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
      reg_clear |=> !reg_clear);
   // R4
   clr_in_busy_chk: assert property (@(posedge clk) disable iff (!arst_n)
      reg_clear |-> busy);
   // R4
   clr_on_start_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !busy && (pin_fall || sw_rst_set) |=> reg_clear);
   // R5
   wr_block_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !busy && (pin_fall || sw_rst_set) |=> wr_block);
   // R3
   pin_end_chk: assert property (@(posedge clk) disable iff (!arst_n)
      busy && !src_soft && expired |=> !busy);
   // R8
   soft_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
      busy && src_soft && !nop_seen && !nop_cmd |=> busy);
   // R10
   nop_idle_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !busy && nop_cmd && !sw_rst_set && !pin_fall |=> !busy);
   // R11
   no_restart_chk: assert property (@(posedge clk) disable iff (!arst_n)
      busy && (pin_fall || sw_rst_set) |=> !reg_clear);
   // R11
   run_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
      busy && !expired |=> busy);
endmodule

bind rst_sequencer rst_sequencer_chk u_chk (
   .clk        (clk),
   .arst_n     (arst_n),
   .sw_rst_set (sw_rst_set),
   .nop_cmd    (nop_cmd),
   .reg_clear  (reg_clear),
   .busy       (busy),
   .wr_block   (wr_block),
   .pin_fall   (pin_fall),
   .expired    (expired),
   .src_soft   (src_q == rseq_pkg::SRC_SOFT),
   .nop_seen   (nop_seen_q)
);

// File: tb/tb_rst_sequencer.sv
module tb_rst_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int SEQ        = 8;

   logic clk = 1'b0;
   logic arst_n, rst_pin_n, sw_rst_set, nop_cmd;
   logic reg_clear, busy, wr_block;

   int checks = 0;
   int fails  = 0;
   int exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rst_sequencer #(.SEQ_CYCLES(SEQ), .SYNC_STAGES(2)) dut (
      .clk        (clk),
      .arst_n     (arst_n),
      .rst_pin_n  (rst_pin_n),
      .sw_rst_set (sw_rst_set),
      .nop_cmd    (nop_cmd),
      .reg_clear  (reg_clear),
      .busy       (busy),
      .wr_block   (wr_block)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic expect_pulse(input int len);
      exp_q.push_back(len);
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: measures every busy pulse and compares with the scoreboard
   int  run_len  = 0;
   bit  clr_bad  = 1'b0;
   bit  blk_bad  = 1'b0;
   always @(negedge clk) begin
      if (arst_n) begin
         if (busy) begin
            if (run_len == 0) check(reg_clear == 1'b1, "R4 clear at start", int'(reg_clear), 1);
            else if (reg_clear) clr_bad = 1'b1;
            if (!wr_block) blk_bad = 1'b1;
            run_len++;
         end else begin
            if (reg_clear) check(1'b0, "R4 clear while idle", 1, 0);
            if (wr_block)  check(1'b0, "R5 block while idle", 1, 0);
            if (run_len > 0) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R6/R10/R11 unexpected pulse", run_len, 0);
               end else begin
                  int e;
                  e = exp_q.pop_front();
                  check(run_len == e, "R3/R8/R9 busy length", run_len, e);
               end
               check(!clr_bad, "R4 clear only once", int'(clr_bad), 0);
               check(!blk_bad, "R5 block follows busy", int'(blk_bad), 0);
               clr_bad = 1'b0;
               blk_bad = 1'b0;
               run_len = 0;
            end
         end
      end
   end

   // Software reset: set at step 0, nop at step m (m<0: none)
   task automatic soft_reset(input int m, input bit nop_with_set);
      sw_rst_set = 1'b1;
      nop_cmd    = nop_with_set;
      @(negedge clk);
      sw_rst_set = 1'b0;
      nop_cmd    = 1'b0;
      check(busy == 1'b1, "R7 soft start", int'(busy), 1);
      if (m > 0) begin
         cycles(m - 1);
         nop_cmd = 1'b1;
         @(negedge clk);
         nop_cmd = 1'b0;
      end
   endtask

   initial begin
      arst_n = 1'b0; rst_pin_n = 1'b1; sw_rst_set = 1'b0; nop_cmd = 1'b0;
      cycles(3);
      check(!busy && !reg_clear && !wr_block, "R1 reset state",
            int'({busy, reg_clear, wr_block}), 0);
      arst_n = 1'b1;
      cycles(2);
      check(!busy && !reg_clear && !wr_block, "R1 after release",
            int'({busy, reg_clear, wr_block}), 0);

      // R2 R3: pin falling edge, latency and length; nop during it ignored
      expect_pulse(SEQ);
      rst_pin_n = 1'b0;
      begin
         int lat = 0;
         for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            if (busy && lat == 0) lat = n;
            if (n == 5) nop_cmd = 1'b1;
            if (n == 6) nop_cmd = 1'b0;
         end
         check(lat == 3, "R2 start latency", lat, 3);
      end
      // R6: pin stays low, no new sequence
      cycles(SEQ + 10);
      check(!busy, "R6 level ignored", int'(busy), 0);

      // R6: new falling edge restarts
      rst_pin_n = 1'b1; cycles(5);
      expect_pulse(SEQ);
      rst_pin_n = 1'b0; cycles(SEQ + 8);
      rst_pin_n = 1'b1; cycles(4);

      // R8: early nop -> SEQ cycles
      expect_pulse(SEQ);
      soft_reset(3, 1'b0);
      cycles(SEQ + 4);
      // R8: late nop -> length equals nop step
      expect_pulse(SEQ + 6);
      soft_reset(SEQ + 6, 1'b0);
      cycles(4);
      // R9: nop together with set does not count
      expect_pulse(SEQ + 3);
      soft_reset(SEQ + 3, 1'b1);
      cycles(4);

      // R10: nop while idle, after soft bit has cleared
      nop_cmd = 1'b1; @(negedge clk); nop_cmd = 1'b0;
      cycles(10);
      check(!busy, "R10 idle nop ignored", int'(busy), 0);

      // R11: requests during a pin sequence are dropped
      expect_pulse(SEQ);
      rst_pin_n = 1'b0;
      cycles(4);
      sw_rst_set = 1'b1; @(negedge clk); sw_rst_set = 1'b0;
      rst_pin_n = 1'b1; cycles(2);
      rst_pin_n = 1'b0; cycles(SEQ + 10);
      check(!busy, "R11 requests during busy dropped", int'(busy), 0);

      cycles(20);
      check(exp_q.size() == 0, "R3 all expected pulses seen", exp_q.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule